// File: doc/BRIEF.md
# Ping-Pong Endpoint Packet Buffer

This block holds outgoing and incoming packets for the main endpoint of a USB peripheral. It has two equal buffers used in turn. Each buffer starts with a two-byte header: a reserved byte at offset 0 and the packet length at offset 1. The payload follows from offset 2. A microcontroller reaches the store through a byte-wide command/data port. A command code rewinds or clears. Every data read or data write after it touches the byte at an internal pointer, and the pointer then steps forward.

A DMA engine has its own access path. DMA accesses never touch the header: the first one lands on offset 2. When a DMA write fills the last payload byte, the buffer is committed. A commit writes its header, flags the buffer full and moves the pointer to the other buffer. The active-low end-of-transfer strobe commits a partly filled buffer early. The packet side sees one full flag per buffer, reads stored bytes through its own read port, and clears a flag once it has sent that packet. There is no guard against running past a buffer's end.

Top module: `ep_pkt_buffer`

## Requirements
- R1: Command code 0xF0 sets the pointer to offset 0 of the active buffer. Each later microcontroller data write stores its byte at the pointer, and each data read returns the byte at the pointer. Each access advances the pointer by one. Offset 0 is the reserved byte, offset 1 the length, and payload starts at offset 2.
- R2: A command code other than 0xF0 and 0xF2 leaves the pointer and the flags unchanged. A transfer broken by such a command resumes at the byte where it stopped.
- R3: Command code 0xF2 clears the full flag of the active buffer. It takes no data and leaves the pointer where it was.
- R4: A DMA read or write issued while the pointer is below 2 acts on offset 2, and the pointer then moves to 3.
- R5: A DMA write to the last payload offset (DATA_BYTES+1) commits the buffer. The commit writes 0 to offset 0 and DATA_BYTES to offset 1, sets that buffer's full flag, switches the active buffer and sets the pointer to 0.
- R6: A DMA write with dma_eot_n low commits the buffer at once. The length byte then holds the number of payload bytes stored, counting that last write.
- R7: dma_eot_n low without a DMA access commits only if at least one payload byte is stored. With the pointer at 0 it has no effect.
- R8: A DMA read of the last payload offset clears the active buffer's full flag, switches the active buffer and sets the pointer to 0.
- R9: After reset both full flags are 0 and buffer 0 is active. A high pkt_sent[i] clears full flag i.
- R10: Pointer overrun is not guarded. Buffer 0 is followed directly by buffer 1 in one flat store. A microcontroller write at offset DATA_BYTES+2 of buffer 0 therefore lands on offset 0 of buffer 1. Accesses past the end of the store write nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe for one cycle |
| cmd_code | input | 8 | Command code (0xF0 buffer access, 0xF2 clear) |
| cpu_wr | input | 1 | Microcontroller data write |
| cpu_wdata | input | 8 | Microcontroller write byte |
| cpu_rd | input | 1 | Microcontroller data read (advances the pointer) |
| cpu_rdata | output | 8 | Byte at the pointer in the active buffer |
| dma_wr | input | 1 | DMA data write |
| dma_wdata | input | 8 | DMA write byte |
| dma_rd | input | 1 | DMA data read (advances the pointer) |
| dma_rdata | output | 8 | Byte at the DMA offset in the active buffer |
| dma_eot_n | input | 1 | Active-low end of DMA transfer |
| pkt_sent | input | 2 | Packet side: clear full flag of buffer i |
| pkt_sel | input | 1 | Packet side read: buffer select |
| pkt_addr | input | 7 | Packet side read: offset within the buffer |
| pkt_rdata | output | 8 | Packet side read data |
| buf_full | output | 2 | Full flag per buffer |
| active_buf | output | 1 | Buffer currently addressed by both access paths |

## Verification
The bench first writes a packet from the microcontroller and reads it back in order. It then reads it again with a foreign command in the middle, which shows that rewinding and resuming differ. DMA writes are applied in three patterns: a short burst that ends with the end-of-transfer strobe, a burst that fills the buffer exactly, and a one-byte burst. Comparing the length byte and the header zeroing across these separates an early commit from a boundary commit. A DMA read that wraps shows the header skip on the read side and the release of the buffer. A microcontroller write stream longer than one buffer shows that overrun spills into the neighbouring buffer.

// File: rtl/epb_pkg.sv
package epb_pkg;

    localparam logic [7:0] CMD_BUFFER = 8'hF0;
    localparam logic [7:0] CMD_CLEAR  = 8'hF2;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_BUFFER,
        OP_CLEAR,
        OP_OTHER
    } op_e;

    // grants of one cycle: command beats microcontroller beats DMA
    typedef struct packed {
        logic cpu;
        logic dma_w;
        logic dma_r;
        logic eot;
    } grant_t;

    function automatic op_e classify(input logic valid, input logic [7:0] code);
        if (!valid)                 return OP_NONE;
        else if (code == CMD_BUFFER) return OP_BUFFER;
        else if (code == CMD_CLEAR)  return OP_CLEAR;
        else                         return OP_OTHER;
    endfunction

endpackage

// File: rtl/epb_cmd_decode.sv
module epb_cmd_decode
    import epb_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    output op_e        op
);
    always_comb op = classify(cmd_valid, cmd_code);
endmodule

// File: rtl/epb_store.sv
module epb_store #(
    parameter  int DATA_BYTES = 64,
    localparam int BUF_BYTES  = DATA_BYTES + 2,
    localparam int DEPTH      = 2 * BUF_BYTES,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW:0]   wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          hdr_en,
    input  logic [AW:0]   hdr_base,
    input  logic [7:0]    hdr_len,
    input  logic [AW:0]   cpu_addr,
    input  logic [AW:0]   dma_addr,
    input  logic [AW:0]   pkt_addr,
    output logic [7:0]    cpu_rdata,
    output logic [7:0]    dma_rdata,
    output logic [7:0]    pkt_rdata
);
    localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && wr_addr < LIMIT) mem[wr_addr[AW-1:0]] <= wr_data;
        if (hdr_en) begin
            mem[hdr_base[AW-1:0]]         <= 8'h00;
            mem[hdr_base[AW-1:0] + 1'b1]  <= hdr_len;
        end
    end

    always_comb begin
        cpu_rdata = (cpu_addr < LIMIT) ? mem[cpu_addr[AW-1:0]] : 8'h00;
        dma_rdata = (dma_addr < LIMIT) ? mem[dma_addr[AW-1:0]] : 8'h00;
        pkt_rdata = (pkt_addr < LIMIT) ? mem[pkt_addr[AW-1:0]] : 8'h00;
    end
endmodule

// File: rtl/epb_seq.sv
module epb_seq
    import epb_pkg::*;
#(
    parameter  int DATA_BYTES = 64,
    localparam int BUF_BYTES  = DATA_BYTES + 2,
    localparam int AW         = $clog2(2 * BUF_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  op_e           op,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic          dma_wr,
    input  logic          dma_rd,
    input  logic          dma_eot_n,
    input  logic [1:0]    pkt_sent,
    output grant_t        grant,
    output logic [AW:0]   cpu_addr,
    output logic [AW:0]   dma_addr,
    output logic          commit,
    output logic [AW:0]   hdr_base,
    output logic [7:0]    hdr_len,
    output logic          sel,
    output logic [1:0]    full
);
    localparam logic [AW-1:0] TWO  = AW'(2);
    localparam logic [AW-1:0] LAST = AW'(BUF_BYTES - 1);

    logic [AW-1:0] ptr, dptr, stored;
    logic          at_end, rd_wrap;

    always_comb begin
        grant.cpu   = (op == OP_NONE) && (cpu_wr || cpu_rd);
        grant.dma_w = (op == OP_NONE) && !grant.cpu && dma_wr;
        grant.dma_r = (op == OP_NONE) && !grant.cpu && !dma_wr && dma_rd;
        grant.eot   = (op == OP_NONE) && !grant.cpu && !dma_eot_n;

        dptr    = (ptr < TWO) ? TWO : ptr;
        at_end  = (dptr == LAST);
        stored  = (ptr > TWO) ? ptr - TWO : '0;
        commit  = (grant.dma_w && (at_end || grant.eot))
                || (grant.eot && !grant.dma_w && !grant.dma_r && stored != '0);
        hdr_len = grant.dma_w ? 8'(dptr - 1'b1) : 8'(stored);
        rd_wrap = grant.dma_r && at_end;

        hdr_base = sel ? (AW+1)'(BUF_BYTES) : '0;
        cpu_addr = hdr_base + {1'b0, ptr};
        dma_addr = hdr_base + {1'b0, dptr};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= '0;
            sel  <= 1'b0;
            full <= '0;
        end else begin
            full <= full & ~pkt_sent;
            unique case (op)
                OP_BUFFER: ptr <= '0;
                OP_CLEAR:  full[sel] <= 1'b0;
                OP_OTHER:  ;
                OP_NONE: begin
                    if (grant.cpu) begin
                        ptr <= ptr + 1'b1;
                    end else if (commit) begin
                        ptr       <= '0;
                        sel       <= ~sel;
                        full[sel] <= 1'b1;
                    end else if (rd_wrap) begin
                        ptr       <= '0;
                        sel       <= ~sel;
                        full[sel] <= 1'b0;
                    end else if (grant.dma_w || grant.dma_r) begin
                        ptr <= dptr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: a buffer command always rewinds
    a_r1_rewind: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BUFFER) |=> (ptr == '0));

    // R1: one microcontroller access steps the pointer by one
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        grant.cpu |=> (ptr == $past(ptr) + 1'b1));

    // R3: clear drops the flag and keeps the pointer
    a_r3_clear_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLEAR) |=> (ptr == $past(ptr)) && !full[$past(sel)]);

    // R4: DMA from the header lands on offset 2
    a_r4_header_skip: assert property (@(posedge clk) disable iff (rst)
        ((grant.dma_w || grant.dma_r) && ptr < TWO && !commit && !rd_wrap)
        |=> (ptr == AW'(3)));

    // R5 R6: a commit flags the buffer and switches
    a_r5_commit_switch: assert property (@(posedge clk) disable iff (rst)
        commit |=> full[$past(sel)] && (sel != $past(sel)) && (ptr == '0));

    // R2: foreign commands are inert
    a_r2_other_inert: assert property (@(posedge clk) disable iff (rst)
        (op == OP_OTHER && pkt_sent == 2'b00) |=> $stable(ptr) && $stable(sel) && $stable(full));
endmodule

// File: rtl/ep_pkt_buffer.sv
module ep_pkt_buffer
    import epb_pkg::*;
#(
    parameter  int DATA_BYTES = 64,
    localparam int BUF_BYTES  = DATA_BYTES + 2,
    localparam int AW         = $clog2(2 * BUF_BYTES),
    localparam int PAW        = $clog2(BUF_BYTES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [7:0]      cmd_code,
    input  logic            cpu_wr,
    input  logic [7:0]      cpu_wdata,
    input  logic            cpu_rd,
    output logic [7:0]      cpu_rdata,
    input  logic            dma_wr,
    input  logic [7:0]      dma_wdata,
    input  logic            dma_rd,
    output logic [7:0]      dma_rdata,
    input  logic            dma_eot_n,
    input  logic [1:0]      pkt_sent,
    input  logic            pkt_sel,
    input  logic [PAW-1:0]  pkt_addr,
    output logic [7:0]      pkt_rdata,
    output logic [1:0]      buf_full,
    output logic            active_buf
);
    op_e          op;
    grant_t       grant;
    logic [AW:0]  cpu_addr, dma_addr, hdr_base, wr_addr, pkt_flat;
    logic [7:0]   hdr_len, wr_data;
    logic         commit, wr_en;

    epb_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .op        (op)
    );

    epb_seq #(.DATA_BYTES(DATA_BYTES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .dma_wr    (dma_wr),
        .dma_rd    (dma_rd),
        .dma_eot_n (dma_eot_n),
        .pkt_sent  (pkt_sent),
        .grant     (grant),
        .cpu_addr  (cpu_addr),
        .dma_addr  (dma_addr),
        .commit    (commit),
        .hdr_base  (hdr_base),
        .hdr_len   (hdr_len),
        .sel       (active_buf),
        .full      (buf_full)
    );

    always_comb begin
        wr_en    = (grant.cpu && cpu_wr) || grant.dma_w;
        wr_addr  = grant.cpu ? cpu_addr : dma_addr;
        wr_data  = grant.cpu ? cpu_wdata : dma_wdata;
        pkt_flat = (pkt_sel ? (AW+1)'(BUF_BYTES) : '0) + (AW+1)'(pkt_addr);
    end

    epb_store #(.DATA_BYTES(DATA_BYTES)) u_store (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .hdr_en    (commit),
        .hdr_base  (hdr_base),
        .hdr_len   (hdr_len),
        .cpu_addr  (cpu_addr),
        .dma_addr  (dma_addr),
        .pkt_addr  (pkt_flat),
        .cpu_rdata (cpu_rdata),
        .dma_rdata (dma_rdata),
        .pkt_rdata (pkt_rdata)
    );
endmodule

// File: tb/test_ep_pkt_buffer.sv
`timescale 1ns/1ps
module test_ep_pkt_buffer;
    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = 8'h00, cpu_rdata;
    logic       dma_wr = 1'b0, dma_rd = 1'b0, dma_eot_n = 1'b1;
    logic [7:0] dma_wdata = 8'h00, dma_rdata;
    logic [1:0] pkt_sent = 2'b00;
    logic       pkt_sel = 1'b0;
    logic [6:0] pkt_addr = 7'd0;
    logic [7:0] pkt_rdata;
    logic [1:0] buf_full;
    logic       active_buf;

    int checks = 0;
    int failures = 0;

    // scoreboard
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       mon_valid = 1'b0;
    logic [7:0] mon_data = 8'h00;

    always #10 clk = ~clk;

    ep_pkt_buffer i_ep_pkt_buffer (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .dma_wr(dma_wr), .dma_wdata(dma_wdata), .dma_rd(dma_rd), .dma_rdata(dma_rdata),
        .dma_eot_n(dma_eot_n), .pkt_sent(pkt_sent), .pkt_sel(pkt_sel),
        .pkt_addr(pkt_addr), .pkt_rdata(pkt_rdata), .buf_full(buf_full),
        .active_buf(active_buf)
    );

    // monitor: pops one expectation per observed byte
    always @(posedge clk) begin
        if (mon_valid) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (mon_data !== e) begin
                failures++;
                $display("FAIL %s: got %02h expected %02h", t, mon_data, e);
            end
        end
    end

    task automatic check(input string t, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %02h expected %02h", t, got, exp);
        end
    endtask

    task automatic finish_pulse();
        @(posedge clk);
        #1;
        cmd_valid = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0;
        dma_wr = 1'b0; dma_rd = 1'b0; dma_eot_n = 1'b1; pkt_sent = 2'b00;
        mon_valid = 1'b0;
    endtask

    task automatic command(input logic [7:0] code);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code;
        finish_pulse();
    endtask

    task automatic cpu_write(input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_wdata = d;
        finish_pulse();
    endtask

    task automatic cpu_read(input logic [7:0] exp, input string t);
        @(negedge clk);
        cpu_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(t);
        mon_data = cpu_rdata; mon_valid = 1'b1;
        finish_pulse();
    endtask

    task automatic dma_write(input logic [7:0] d, input logic eot);
        @(negedge clk);
        dma_wr = 1'b1; dma_wdata = d; dma_eot_n = ~eot;
        finish_pulse();
    endtask

    task automatic dma_read(input logic chk, input logic [7:0] exp, input string t);
        @(negedge clk);
        dma_rd = 1'b1;
        if (chk) begin
            exp_q.push_back(exp); tag_q.push_back(t);
            mon_data = dma_rdata; mon_valid = 1'b1;
        end
        finish_pulse();
    endtask

    task automatic pkt_check(input logic s, input logic [6:0] a, input logic [7:0] exp, input string t);
        @(negedge clk);
        pkt_sel = s; pkt_addr = a;
        #1;
        check(t, pkt_rdata, exp);
    endtask

    task automatic flags_check(input logic [1:0] f, input logic a, input string t);
        @(negedge clk);
        check({t, " full"}, {6'd0, buf_full}, {6'd0, f});
        check({t, " active"}, {7'd0, active_buf}, {7'd0, a});
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R9 reset state
        flags_check(2'b00, 1'b0, "R9 reset");

        // R1 write a packet then read it back in order
        command(8'hF0);
        cpu_write(8'h55); cpu_write(8'h03);
        cpu_write(8'hA1); cpu_write(8'hA2); cpu_write(8'hA3);
        command(8'hF0);
        cpu_read(8'h55, "R1 byte0"); cpu_read(8'h03, "R1 len");
        cpu_read(8'hA1, "R1 d1"); cpu_read(8'hA2, "R1 d2"); cpu_read(8'hA3, "R1 d3");

        // R2 foreign command in the middle resumes; R1 rewind restarts
        command(8'hF0);
        cpu_read(8'h55, "R2 pre0"); cpu_read(8'h03, "R2 pre1");
        command(8'h40);
        cpu_read(8'hA1, "R2 resume");
        command(8'hF0);
        cpu_read(8'h55, "R1 rewind");

        // R4 R6 short DMA burst ended by the strobe
        command(8'hF0);
        for (int i = 0; i < 5; i++) dma_write(8'h0A + 8'(i), i == 4);
        flags_check(2'b01, 1'b1, "R6 partial commit");
        pkt_check(1'b0, 7'd0, 8'h00, "R6 byte0 zeroed");
        pkt_check(1'b0, 7'd1, 8'h05, "R6 length");
        pkt_check(1'b0, 7'd2, 8'h0A, "R4 first dma at offset 2");
        pkt_check(1'b0, 7'd6, 8'h0E, "R6 last byte");

        // R5 DMA burst that fills buffer 1 exactly
        for (int i = 0; i < 64; i++) dma_write(8'h40 + 8'(i), 1'b0);
        flags_check(2'b11, 1'b0, "R5 boundary commit");
        pkt_check(1'b1, 7'd1, 8'd64, "R5 length");
        pkt_check(1'b1, 7'd2, 8'h40, "R5 first");
        pkt_check(1'b1, 7'd65, 8'h7F, "R5 last");

        // R7 strobe alone with nothing stored
        @(negedge clk);
        dma_eot_n = 1'b0;
        finish_pulse();
        flags_check(2'b11, 1'b0, "R7 idle strobe");

        // R8 R4 DMA read of buffer 0 until it wraps
        command(8'hF0);
        dma_read(1'b1, 8'h0A, "R4 read skip d1");
        dma_read(1'b1, 8'h0B, "R4 read d2");
        for (int i = 0; i < 62; i++) dma_read(1'b0, 8'h00, "");
        flags_check(2'b10, 1'b1, "R8 read wrap");

        // R3 clear takes no data and keeps the pointer
        command(8'hF0);
        cpu_read(8'h00, "R3 pre byte0");
        command(8'hF2);
        flags_check(2'b00, 1'b1, "R3 cleared");
        cpu_read(8'd64, "R3 pointer kept");

        // R6 one-byte burst, then R9 packet side release
        command(8'hF0);
        dma_write(8'h99, 1'b1);
        flags_check(2'b10, 1'b0, "R6 single byte");
        pkt_check(1'b1, 7'd1, 8'h01, "R6 length one");
        pkt_check(1'b1, 7'd2, 8'h99, "R6 data");
        @(negedge clk);
        pkt_sent = 2'b10;
        finish_pulse();
        flags_check(2'b00, 1'b0, "R9 pkt_sent");

        // R10 overrun spills into buffer 1
        command(8'hF0);
        for (int i = 0; i < 67; i++) cpu_write(8'(i));
        pkt_check(1'b0, 7'd65, 8'd65, "R10 last own byte");
        pkt_check(1'b1, 7'd0, 8'd66, "R10 spill");
        pkt_check(1'b1, 7'd1, 8'h01, "R10 neighbour length intact");

        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule